// File: doc/BRIEF.md
# Supervisory Audio Tone Manager

This block handles the supervisory tone of an analog cellular voice channel, working entirely from one 8.064 MHz system clock. On the transmit side it synthesises a digital square wave at one of three closely spaced frequencies (5970 Hz, 6000 Hz or 6030 Hz) with a phase accumulator. On the receive side it takes a digitised, asynchronous tone input, times a fixed number of its periods in clock cycles and sorts the result into one of the three frequencies or "none".

A reported tone is qualified: it appears only when two measurements in a row agree, and it disappears only when two measurements in a row find nothing valid. A missing input still yields measurements, because a measurement that runs past the longest valid count ends as "none". In loopback (transponding) mode the transmit side follows the detected code rather than the programmed selection. A small two-address register interface carries control and status, and any change of the reported code raises a sticky interrupt request.

Top module: `sat_tone_mgr`

## Requirements
- R1: After reset `tx_tone` is low, `tone_code` is 00, `irq` is low and both registers read as 0x00.
- R2: Address 0 is control: bit 0 transmit enable, bits 2:1 frequency select (01 = 5970 Hz, 10 = 6000 Hz, 11 = 6030 Hz), bit 3 loopback enable; bits 7:4 read 0. Address 1 is status: bits 1:0 the reported code, bit 2 the interrupt flag, other bits read 0. Writes take effect at the next clock edge; reads are combinational.
- R3: With transmit enabled and select 01, 10 or 11, consecutive rising edges of `tx_tone` are floor(8064000/f) or floor(8064000/f)+1 clock cycles apart, f being the selected frequency.
- R4: `tx_tone` stays low whenever transmit is disabled or the effective selection is 00.
- R5: The detector times EDGES received periods (default 16) in clock cycles. With nominal counts N(f) = floor(8064000*EDGES/f), a count of at most N(5970)+(N(5970)-N(6000))/2 and at least halfway (rounded up) between N(5970) and N(6000) is code 01; from halfway between N(6000) and N(6030) up to just below the 01 range is code 10; from N(6030)-(N(6000)-N(6030))/2 up to just below the 10 range is code 11; anything else is 00.
- R6: `tone_code` changes to a tone code only after two consecutive measurements both give that code.
- R7: `tone_code` returns to 00 only after two consecutive measurements give 00; a measurement whose count passes the upper limit without completing ends as 00, so a stopped input is reported lost.
- R8: With loopback enabled the transmit frequency follows `tone_code` instead of the select field, and `tx_tone` is low while `tone_code` is 00.
- R9: Any change of `tone_code` sets the interrupt flag, which drives `irq`; writing 1 to status bit 2 clears it, writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.064 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 control, 1 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rx_tone | input | 1 | Digitised received tone, asynchronous |
| tx_tone | output | 1 | Generated square-wave tone |
| tone_code | output | 2 | Qualified detected tone code |
| irq | output | 1 | Interrupt request, high while the flag is set |

## Verification
A corrupted phase accumulator or increment shows up on `tx_tone` within one tone period as an edge spacing outside the one-cycle tolerance. A wrong period counter or window boundary appears on `tone_code` within two measurement windows (roughly 2*EDGES periods) as a missing, early or wrong code, while a broken agreement rule shows as a report after a single window. Interrupt flag faults surface on `irq` and status bit 2 at the first code change or clear write.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    TONE_NONE = 2'b00,
    TONE_LO   = 2'b01,
    TONE_MID  = 2'b10,
    TONE_HI   = 2'b11
  } tone_code_t;

  // Rounded phase step for a tone of freq_hz in an accumulator of acc_w bits.
  function automatic longint phase_inc(input int freq_hz, input int clk_hz, input int acc_w);
    longint num;
    num = (longint'(freq_hz) << acc_w) + longint'(clk_hz) / 2;
    return num / longint'(clk_hz);
  endfunction

endpackage

// File: rtl/sat_sync_edge.sv
module sat_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/sat_tone_gen.sv
module sat_tone_gen
  import sat_pkg::*;
#(
  parameter int CLK_HZ = 8064000,
  parameter int ACC_W  = 24,
  parameter int F_LO   = 5970,
  parameter int F_MID  = 6000,
  parameter int F_HI   = 6030
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  tone_code_t sel,
  output logic       tx
);
  localparam logic [ACC_W-1:0] STEP_LO  = ACC_W'(phase_inc(F_LO,  CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] STEP_MID = ACC_W'(phase_inc(F_MID, CLK_HZ, ACC_W));
  localparam logic [ACC_W-1:0] STEP_HI  = ACC_W'(phase_inc(F_HI,  CLK_HZ, ACC_W));

  logic [ACC_W-1:0] acc_q, acc_d, step;
  logic             active;

  always_comb begin
    active = en && (sel != TONE_NONE);
    unique case (sel)
      TONE_LO:  step = STEP_LO;
      TONE_MID: step = STEP_MID;
      TONE_HI:  step = STEP_HI;
      default:  step = '0;
    endcase
    acc_d = active ? acc_q + step : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign tx = acc_q[ACC_W-1];

  // R4: an idle generator leaves the output low one edge later
  a_r4_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !tx);

endmodule

// File: rtl/sat_tone_det.sv
module sat_tone_det
  import sat_pkg::*;
#(
  parameter int CLK_HZ = 8064000,
  parameter int EDGES  = 16,
  parameter int F_LO   = 5970,
  parameter int F_MID  = 6000,
  parameter int F_HI   = 6030
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  output tone_code_t code,
  output logic       code_chg
);
  localparam int NOM_LO  = (CLK_HZ * EDGES) / F_LO;
  localparam int NOM_MID = (CLK_HZ * EDGES) / F_MID;
  localparam int NOM_HI  = (CLK_HZ * EDGES) / F_HI;
  localparam int BND_LM  = (NOM_LO + NOM_MID + 1) / 2;
  localparam int BND_MH  = (NOM_MID + NOM_HI + 1) / 2;
  localparam int CNT_MAX = NOM_LO + (NOM_LO - NOM_MID) / 2;
  localparam int CNT_MIN = NOM_HI - (NOM_MID - NOM_HI) / 2;
  localparam int CW      = $clog2(CNT_MAX + 2);
  localparam int EW      = (EDGES > 1) ? $clog2(EDGES) : 1;

  localparam logic [CW-1:0] LIM_MAX = CW'(CNT_MAX);
  localparam logic [CW-1:0] LIM_MIN = CW'(CNT_MIN);
  localparam logic [CW-1:0] LIM_LM  = CW'(BND_LM);
  localparam logic [CW-1:0] LIM_MH  = CW'(BND_MH);
  localparam logic [EW-1:0] LAST_E  = EW'(EDGES - 1);

  logic          armed_q, armed_d;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic [CW-1:0] cyc_q, cyc_d, cyc_inc;
  tone_code_t    prev_q, prev_d, code_q, code_d, meas;
  logic          start, done, tmo, meas_valid;

  always_comb begin
    cyc_inc = cyc_q + 1'b1;
    start   = !armed_q && rise;
    done    = armed_q && rise && (ecnt_q == LAST_E);
    tmo     = !start && !done && (cyc_inc > LIM_MAX);
    meas_valid = done || tmo;

    meas = TONE_NONE;
    if (done) begin
      if      (cyc_inc >= LIM_LM && cyc_inc <= LIM_MAX) meas = TONE_LO;
      else if (cyc_inc >= LIM_MH && cyc_inc <  LIM_LM)  meas = TONE_MID;
      else if (cyc_inc >= LIM_MIN && cyc_inc < LIM_MH)  meas = TONE_HI;
    end

    armed_d = armed_q;
    ecnt_d  = ecnt_q;
    cyc_d   = cyc_inc;
    if (start) begin
      armed_d = 1'b1;
      ecnt_d  = '0;
      cyc_d   = '0;
    end else if (done) begin
      ecnt_d  = '0;
      cyc_d   = '0;
    end else if (tmo) begin
      armed_d = 1'b0;
      ecnt_d  = '0;
      cyc_d   = '0;
    end else if (armed_q && rise) begin
      ecnt_d  = ecnt_q + 1'b1;
    end

    prev_d = prev_q;
    code_d = code_q;
    if (meas_valid) begin
      prev_d = meas;
      if (meas == prev_q) code_d = meas;
    end
    code_chg = (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ecnt_q  <= '0;
      cyc_q   <= '0;
      prev_q  <= TONE_NONE;
      code_q  <= TONE_NONE;
    end else begin
      armed_q <= armed_d;
      ecnt_q  <= ecnt_d;
      cyc_q   <= cyc_d;
      prev_q  <= prev_d;
      code_q  <= code_d;
    end
  end

  assign code = code_q;

  // R7: the period counter never runs past the upper window limit
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= LIM_MAX);

  // R6: the reported code moves only right after a finished measurement
  a_r6_moves_on_meas: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(meas_valid));

  // R6: the new code equals the measurement that preceded it
  a_r6_two_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> (code_q == $past(prev_q)));

endmodule

// File: rtl/sat_tone_mgr.sv
module sat_tone_mgr
  import sat_pkg::*;
#(
  parameter int CLK_HZ = 8064000,
  parameter int EDGES  = 16,
  parameter int ACC_W  = 24,
  parameter int F_LO   = 5970,
  parameter int F_MID  = 6000,
  parameter int F_HI   = 6030
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_tone,
  output logic       tx_tone,
  output logic [1:0] tone_code,
  output logic       irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic       tx_en_q, tx_en_d, loop_q, loop_d, irq_q, irq_d;
  tone_code_t fsel_q, fsel_d, det_code, gen_sel;
  logic       det_chg, rise, wr_ctrl, wr_stat;
  logic       unused_wbits;

  assign unused_wbits = ^reg_wdata[7:4];

  always_comb begin
    wr_ctrl = reg_wr && !reg_addr;
    wr_stat = reg_wr &&  reg_addr;
    tx_en_d = wr_ctrl ? reg_wdata[0] : tx_en_q;
    fsel_d  = wr_ctrl ? tone_code_t'(reg_wdata[2:1]) : fsel_q;
    loop_d  = wr_ctrl ? reg_wdata[3] : loop_q;
    irq_d   = irq_q;
    if (wr_stat && reg_wdata[2]) irq_d = 1'b0;
    if (det_chg)                 irq_d = 1'b1;
    gen_sel = loop_q ? det_code : fsel_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tx_en_q <= 1'b0;
      fsel_q  <= TONE_NONE;
      loop_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      tx_en_q <= tx_en_d;
      fsel_q  <= fsel_d;
      loop_q  <= loop_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    if (!reg_addr) reg_rdata = {4'b0000, loop_q, fsel_q, tx_en_q};
    else           reg_rdata = {5'b00000, irq_q, det_code};
  end

  sat_sync_edge #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_i),
    .din  (rx_tone),
    .rise (rise)
  );

  sat_tone_det #(
    .CLK_HZ(CLK_HZ), .EDGES(EDGES), .F_LO(F_LO), .F_MID(F_MID), .F_HI(F_HI)
  ) u_det (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .rise    (rise),
    .code    (det_code),
    .code_chg(det_chg)
  );

  sat_tone_gen #(
    .CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .F_LO(F_LO), .F_MID(F_MID), .F_HI(F_HI)
  ) u_gen (
    .clk  (clk),
    .rst_n(rst_n_i),
    .en   (tx_en_q),
    .sel  (gen_sel),
    .tx   (tx_tone)
  );

  assign tone_code = det_code;
  assign irq       = irq_q;

  // R9: a code change leaves the flag raised
  a_r9_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n_i)
    !$stable(tone_code) |-> irq);

  // R9: only a clear write drops the flag
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq && !(reg_wr && reg_addr && reg_wdata[2])) |=> irq);

  // R8: in loopback a lost tone silences the transmitter
  a_r8_loop_silent: assert property (@(posedge clk) disable iff (!rst_n_i)
    (loop_q && tone_code == 2'b00) |=> !tx_tone);

endmodule

// File: tb/sat_tone_mgr_test.sv
module sat_tone_mgr_test;
  localparam int CLK_PERIOD = 124;
  localparam int EDGES      = 4;
  localparam int CLK_HZ     = 8064000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_tone = 1'b0;
  logic       tx_tone;
  logic [1:0] tone_code;
  logic       irq;

  sat_tone_mgr #(.EDGES(EDGES)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_tone(rx_tone),
    .tx_tone(tx_tone), .tone_code(tone_code), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int last_rise = 0;
  int tone_p = 0;
  bit finished = 1'b0;

  int    exp_code[$];
  string exp_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rng(string req, int act, int lo, int hi);
    vectors++;
    if (act < lo || act > hi) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic expect_code(string req, int c);
    exp_code.push_back(c);
    exp_req.push_back(req);
  endtask

  task automatic wait_tx_rise(output int t);
    logic last;
    last = tx_tone;
    forever begin
      @(negedge clk);
      if (tx_tone && !last) break;
      last = tx_tone;
    end
    t = cyc;
  endtask

  task automatic tx_period(string req, int f);
    int lo, t0, t1;
    lo = CLK_HZ / f;
    wait_tx_rise(t0);
    for (int k = 0; k < 3; k++) begin
      wait_tx_rise(t1);
      check_rng(req, t1 - t0, lo, lo + 1);
      t0 = t1;
    end
  endtask

  task automatic tx_quiet(string req, int n);
    int hi;
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (tx_tone) hi++;
    end
    check(req, hi, 0);
  endtask

  // received tone source
  initial begin
    forever begin
      if (tone_p == 0) begin
        rx_tone = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = tone_p;
        rx_tone = 1'b1;
        rise_cnt++;
        last_rise = cyc;
        repeat (p / 2) @(negedge clk);
        rx_tone = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  // scoreboard monitor: every code change must match the next expected item
  initial begin
    int prev;
    prev = 0;
    forever begin
      @(negedge clk);
      if (int'(tone_code) != prev) begin
        if (exp_code.size() == 0) begin
          check("R6 unexpected code change", int'(tone_code), prev);
        end else begin
          int e;
          string r;
          e = exp_code.pop_front();
          r = exp_req.pop_front();
          check(r, int'(tone_code), e);
        end
        prev = int'(tone_code);
      end
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int v, base, lr;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    check("R1 tx", int'(tx_tone), 0);
    check("R1 code", int'(tone_code), 0);
    check("R1 irq", int'(irq), 0);
    rd(1'b0, v); check("R1 ctrl read", v, 0);
    rd(1'b1, v); check("R1 status read", v, 0);

    // R2/R3 generation at all three selections
    wr(1'b0, 8'h05);
    rd(1'b0, v); check("R2 ctrl readback", v, 5);
    tx_period("R3 6000 Hz", 6000);
    wr(1'b0, 8'h03);
    tx_period("R3 5970 Hz", 5970);
    wr(1'b0, 8'hF7);
    rd(1'b0, v); check("R2 upper bits read zero", v, 7);
    tx_period("R3 6030 Hz", 6030);

    // R4 quiet output
    wr(1'b0, 8'h01);
    tx_quiet("R4 select 00", 3000);
    wr(1'b0, 8'h04);
    tx_quiet("R4 disabled", 3000);

    // R5/R6 detection of 6000 Hz, qualified by two windows
    expect_code("R5 detect 6000", 2);
    base = rise_cnt;
    tone_p = 1344;
    wait (rise_cnt == base + 8);
    tick(10);
    check("R6 one window not enough", int'(tone_code), 0);
    wait (rise_cnt == base + 9);
    tick(10);
    check("R6 reported after two windows", int'(tone_code), 2);

    // R9 interrupt flag
    check("R9 irq raised", int'(irq), 1);
    rd(1'b1, v); check("R9 status read", v, 6);
    wr(1'b1, 8'h00);
    check("R9 zero write keeps flag", int'(irq), 1);
    wr(1'b1, 8'h04);
    check("R9 clear", int'(irq), 0);
    rd(1'b1, v); check("R9 status after clear", v, 2);

    // R5 change to 6030 Hz
    expect_code("R5 detect 6030", 3);
    base = rise_cnt;
    tone_p = 1337;
    wait (rise_cnt == base + 17);
    tick(20);
    check("R5 code 6030", int'(tone_code), 3);
    check("R9 irq on second change", int'(irq), 1);

    // R8 loopback overrides select 01
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R2 loopback readback", v, 11);
    tx_period("R8 loop 6030", 6030);

    // R5 out-of-window tone reads as none; loopback goes quiet
    expect_code("R5 out of window", 0);
    base = rise_cnt;
    tone_p = 1300;
    wait (rise_cnt == base + 17);
    tick(20);
    check("R5 code none", int'(tone_code), 0);
    tx_quiet("R8 loop with none", 3000);

    // R5 5970 Hz, loopback follows it
    expect_code("R5 detect 5970", 1);
    base = rise_cnt;
    tone_p = 1351;
    wait (rise_cnt == base + 17);
    tick(20);
    check("R5 code 5970", int'(tone_code), 1);
    tx_period("R8 loop 5970", 5970);

    // R7 loss when the input stops
    expect_code("R7 tone lost", 0);
    tone_p = 0;
    tick(1400);
    lr = last_rise;
    wait (cyc >= lr + 5000);
    tick(1);
    check("R7 held after one empty window", int'(tone_code), 1);
    wait (cyc >= lr + 11500);
    tick(1);
    check("R7 lost after two empty windows", int'(tone_code), 0);

    tick(5);
    check("R5 scoreboard drained", exp_code.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule